// File: doc/BRIEF.md
# Single-Pending-Operand Issue Queue

This block holds decoded instructions from several hardware threads until their source operands are available, then sends them to execution oldest first. Each entry can wait on only one source tag. An instruction that arrives with both sources unready is refused. The dispatch stage keeps it and offers it again in later cycles. A result tag broadcast on a wakeup port in the same cycle counts as making that source ready, so a refused instruction gets in as soon as one of its producers broadcasts. Renaming, the register file and the execution units are outside the block. Tags, readiness bits and an opaque payload arrive on the dispatch port.

Dispatch is a valid/ready stream. The dispatch stage must hold all fields stable while `disp_valid` is high and `disp_ready` is low. A transfer happens on a clock edge where both are high. `disp_ready` is low when any of these is true: no entry is free, both sources are unready after the same-cycle wakeup is counted, or the instruction's thread is being flushed in that cycle. Issue is a valid/ready stream with up to `ISSUE_W` slots, and the slots are packed from slot 0. A single `iss_ready` lets all offered slots issue at once. With `iss_ready` low, nothing is offered and nothing leaves the queue. An entry that issues is free again in the following cycle.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty. `full` is low, no issue slot is valid, `stall` is low while `disp_valid` is low, and an instruction with ready sources sees `disp_ready` high.
- R2: An instruction whose two sources are both unready, with no matching wakeup in that cycle, sees `disp_ready` low and `stall` high. It is not written into the queue.
- R3: An accepted instruction with both sources ready is offered on issue slot 0 in the cycle after acceptance, provided no older ready entry exists.
- R4: An entry that waits on one tag becomes ready only on a valid wakeup port whose tag equals its pending tag. It is offered for issue in the cycle after that wakeup. A valid wakeup with a different tag leaves it waiting.
- R5: A wakeup that matches one of the two unready sources in the same cycle as dispatch raises `disp_ready`. The accepted entry then waits on the other source.
- R6: Up to `ISSUE_W` ready entries are offered per cycle, ordered by age: slot 0 carries the oldest ready entry, slot 1 the next oldest, and so on. Offered slots are contiguous from slot 0.
- R7: Each issue slot carries the thread ID and the payload that were dispatched with that instruction.
- R8: When bit t of `flush` is high, every entry of thread t is invalidated at that clock edge, and entries of other threads are kept. A dispatch from thread t in that cycle sees `disp_ready` low.
- R9: `full` is high exactly when all `DEPTH` entries are valid. While `full` is high, `disp_ready` is low and no valid entry is overwritten. An entry freed by issue can be reused from the next cycle on.
- R10: While `iss_ready` is low, no issue slot is valid and every entry keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | Queue accepts the offered instruction this cycle |
| disp_tid | input | TID_W | Thread of the offered instruction |
| disp_s0_rdy | input | 1 | First source already available |
| disp_s0_tag | input | TAG_W | Producer tag of the first source |
| disp_s1_rdy | input | 1 | Second source already available |
| disp_s1_tag | input | TAG_W | Producer tag of the second source |
| disp_payload | input | PAY_W | Opaque instruction payload |
| wake_valid | input | WAKE_W | One bit per wakeup port: tag on that port is valid |
| wake_tag | input | WAKE_W*TAG_W | Broadcast result tags, port w at bits [w*TAG_W +: TAG_W] |
| flush | input | THREADS | One bit per thread: discard that thread's entries |
| iss_ready | input | 1 | Execution accepts every offered slot |
| iss_valid | output | ISSUE_W | Slot k carries an instruction |
| iss_tid | output | ISSUE_W*TID_W | Thread ID per slot |
| iss_payload | output | ISSUE_W*PAY_W | Payload per slot |
| full | output | 1 | No free entry |
| stall | output | 1 | Dispatch offered but refused this cycle |

## Verification
A corrupted age rank shows at the ports within one cycle of two entries becoming ready together: the younger payload appears on slot 0. A missed or spurious tag match shows as an entry that never issues, or that issues before its wakeup, and is visible in the cycle after the broadcast. A lost valid bit shows as `full` changing at the wrong count, or as a payload missing from the issue stream. A failed flush shows as a flushed payload on an issue slot once its tag wakes it.

// File: rtl/iq_pkg.sv
package iq_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/iq_rank.sv
// For each entry, counts the masked entries that are strictly older.
module iq_rank #(
  parameter int N  = 64,
  parameter int AW = 6
) (
  input  logic [AW-1:0] age  [N],
  input  logic [N-1:0]  mask,
  output logic [AW-1:0] cnt  [N]
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      cnt[i] = '0;
      for (int j = 0; j < N; j++)
        if (mask[j] && (age[j] < age[i])) cnt[i] = cnt[i] + AW'(1);
    end
  end
endmodule

// File: rtl/iq_slot.sv
// One queue entry with a single pending-tag comparator.
module iq_slot #(
  parameter int TAG_W  = 7,
  parameter int PAY_W  = 32,
  parameter int TID_W  = 2,
  parameter int AW     = 6,
  parameter int WAKE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [TID_W-1:0] in_tid,
  input  logic             in_rdy,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [PAY_W-1:0] in_pay,
  input  logic [AW-1:0]    in_age,
  input  logic [WAKE_W-1:0] wk_vld,
  input  logic [TAG_W-1:0] wk_tag [WAKE_W],
  input  logic             kill,
  input  logic             grant,
  input  logic [AW-1:0]    older_gone,
  output logic             valid_q,
  output logic             ready_q,
  output logic [TID_W-1:0] tid_q,
  output logic [PAY_W-1:0] pay_q,
  output logic [AW-1:0]    age_q
);
  logic [TAG_W-1:0] tag_q;
  logic             hit;

  always_comb begin
    hit = 1'b0;
    for (int w = 0; w < WAKE_W; w++)
      if (wk_vld[w] && (wk_tag[w] == tag_q)) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      tid_q   <= '0;
      pay_q   <= '0;
      age_q   <= '0;
      tag_q   <= '0;
    end else if (alloc) begin
      valid_q <= 1'b1;
      ready_q <= in_rdy;
      tid_q   <= in_tid;
      pay_q   <= in_pay;
      age_q   <= in_age;
      tag_q   <= in_tag;
    end else if (valid_q && kill) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (!ready_q && hit) ready_q <= 1'b1;
      age_q <= age_q - older_gone;
    end
  end

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid_q);
  // R8
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kill && !alloc) |=> !valid_q);
  // R4
  stays_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_q && !kill && !grant) |=> (valid_q && ready_q));
  // R10
  grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (valid_q && ready_q));
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TAG_W   = 7,
  parameter int PAY_W   = 32,
  parameter int THREADS = 4,
  parameter int WAKE_W  = 4,
  parameter int ISSUE_W = 2,
  localparam int TID_W  = idx_w(THREADS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic [TID_W-1:0]           disp_tid,
  input  logic                       disp_s0_rdy,
  input  logic [TAG_W-1:0]           disp_s0_tag,
  input  logic                       disp_s1_rdy,
  input  logic [TAG_W-1:0]           disp_s1_tag,
  input  logic [PAY_W-1:0]           disp_payload,
  input  logic [WAKE_W-1:0]          wake_valid,
  input  logic [WAKE_W*TAG_W-1:0]    wake_tag,
  input  logic [THREADS-1:0]         flush,
  input  logic                       iss_ready,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*TID_W-1:0]   iss_tid,
  output logic [ISSUE_W*PAY_W-1:0]   iss_payload,
  output logic                       full,
  output logic                       stall
);
  localparam int AW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] wk_tag [WAKE_W];
  for (genvar w = 0; w < WAKE_W; w++) begin : g_wk
    assign wk_tag[w] = wake_tag[w*TAG_W +: TAG_W];
  end

  // Dispatch side: same-cycle wakeup folded into source readiness.
  logic hit0, hit1, eff0, eff1, accept;
  always_comb begin
    hit0 = 1'b0;
    hit1 = 1'b0;
    for (int w = 0; w < WAKE_W; w++) begin
      if (wake_valid[w] && (wk_tag[w] == disp_s0_tag)) hit0 = 1'b1;
      if (wake_valid[w] && (wk_tag[w] == disp_s1_tag)) hit1 = 1'b1;
    end
  end
  assign eff0 = disp_s0_rdy | hit0;
  assign eff1 = disp_s1_rdy | hit1;

  logic [DEPTH-1:0] s_v, s_r, flushed, cand, grant, removed, alloc_oh;
  logic [TID_W-1:0] s_tid [DEPTH];
  logic [PAY_W-1:0] s_pay [DEPTH];
  logic [AW-1:0]    s_age [DEPTH];
  logic [AW-1:0]    rk_rdy [DEPTH];
  logic [AW-1:0]    rk_rem [DEPTH];

  assign full       = &s_v;
  assign disp_ready = !full && (eff0 || eff1) && !flush[disp_tid];
  assign accept     = disp_valid && disp_ready;
  assign stall      = disp_valid && !disp_ready;

  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!s_v[i] && !found) begin
        alloc_oh[i] = accept;
        found       = 1'b1;
      end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign flushed[i] = s_v[i] && flush[s_tid[i]];
    assign cand[i]    = s_v[i] && s_r[i] && !flushed[i];
    assign grant[i]   = cand[i] && iss_ready && (int'(rk_rdy[i]) < ISSUE_W);
  end
  assign removed = grant | flushed;

  iq_rank #(.N(DEPTH), .AW(AW)) u_rank_rdy (.age(s_age), .mask(cand),    .cnt(rk_rdy));
  iq_rank #(.N(DEPTH), .AW(AW)) u_rank_rem (.age(s_age), .mask(removed), .cnt(rk_rem));

  logic [CW-1:0] n_val, n_rem;
  logic [AW-1:0] ins_age;
  always_comb begin
    n_val = '0;
    n_rem = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_val = n_val + CW'(s_v[i]);
      n_rem = n_rem + CW'(removed[i]);
    end
  end
  assign ins_age = AW'(n_val - n_rem);

  // Entry waits on the first still-unready source.
  logic [TAG_W-1:0] ins_tag;
  assign ins_tag = eff0 ? disp_s1_tag : disp_s0_tag;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    iq_slot #(.TAG_W(TAG_W), .PAY_W(PAY_W), .TID_W(TID_W), .AW(AW), .WAKE_W(WAKE_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_oh[i]),
      .in_tid     (disp_tid),
      .in_rdy     (eff0 && eff1),
      .in_tag     (ins_tag),
      .in_pay     (disp_payload),
      .in_age     (ins_age),
      .wk_vld     (wake_valid),
      .wk_tag     (wk_tag),
      .kill       (removed[i]),
      .grant      (grant[i]),
      .older_gone (rk_rem[i]),
      .valid_q    (s_v[i]),
      .ready_q    (s_r[i]),
      .tid_q      (s_tid[i]),
      .pay_q      (s_pay[i]),
      .age_q      (s_age[i])
    );
  end

  always_comb begin
    iss_valid   = '0;
    iss_tid     = '0;
    iss_payload = '0;
    for (int k = 0; k < ISSUE_W; k++)
      for (int i = 0; i < DEPTH; i++)
        if (grant[i] && (int'(rk_rdy[i]) == k)) begin
          iss_valid[k]                   = 1'b1;
          iss_tid[k*TID_W +: TID_W]      = s_tid[i];
          iss_payload[k*PAY_W +: PAY_W]  = s_pay[i];
        end
  end

  // R9
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);
  // R2
  two_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_s0_rdy && !disp_s1_rdy && (wake_valid == '0)) |-> !disp_ready);
  // R10
  hold_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (iss_valid == '0));
  // R8
  flush_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush[disp_tid] |-> !disp_ready);
  for (genvar k = 1; k < ISSUE_W; k++) begin : g_pack
    // R6
    slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> iss_valid[k-1]);
  end
endmodule

// File: tb/test_issue_queue.sv
`timescale 1ns/1ps
module test_issue_queue;
  localparam int DEPTH = 4, TAG_W = 6, PAY_W = 8, THREADS = 2, WAKE_W = 2, ISSUE_W = 2;
  localparam int TID_W = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_s0_rdy = 0, disp_s1_rdy = 0, iss_ready = 0;
  logic [TID_W-1:0] disp_tid = '0;
  logic [TAG_W-1:0] disp_s0_tag = '0, disp_s1_tag = '0;
  logic [PAY_W-1:0] disp_payload = '0;
  logic [WAKE_W-1:0] wake_valid = '0;
  logic [WAKE_W*TAG_W-1:0] wake_tag = '0;
  logic [THREADS-1:0] flush = '0;
  logic disp_ready, full, stall;
  logic [ISSUE_W-1:0] iss_valid;
  logic [ISSUE_W*TID_W-1:0] iss_tid;
  logic [ISSUE_W*PAY_W-1:0] iss_payload;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W), .THREADS(THREADS),
                .WAKE_W(WAKE_W), .ISSUE_W(ISSUE_W)) i_issue_queue (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tid(disp_tid), .disp_s0_rdy(disp_s0_rdy), .disp_s0_tag(disp_s0_tag),
    .disp_s1_rdy(disp_s1_rdy), .disp_s1_tag(disp_s1_tag), .disp_payload(disp_payload),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .flush(flush), .iss_ready(iss_ready),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_payload(iss_payload),
    .full(full), .stall(stall));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic tid, input logic r0, input logic [5:0] t0,
                       input logic r1, input logic [5:0] t1, input logic [7:0] pay);
    disp_valid = 1; disp_tid = tid; disp_s0_rdy = r0; disp_s0_tag = t0;
    disp_s1_rdy = r1; disp_s1_tag = t1; disp_payload = pay;
  endtask

  // {tid, s0_rdy, s0_tag, s1_rdy, s1_tag, payload, expect_accept}
  localparam int VW = 24;
  localparam logic [VW-1:0] VEC [6] = '{
    {1'b0, 1'b1, 6'd0, 1'b1, 6'd0, 8'd1, 1'b1},
    {1'b0, 1'b1, 6'd0, 1'b0, 6'd5, 8'd2, 1'b1},
    {1'b1, 1'b0, 6'd6, 1'b0, 6'd7, 8'd3, 1'b0},
    {1'b1, 1'b1, 6'd0, 1'b1, 6'd0, 8'd4, 1'b1},
    {1'b0, 1'b1, 6'd0, 1'b1, 6'd0, 8'd5, 1'b1},
    {1'b1, 1'b1, 6'd0, 1'b1, 6'd0, 8'd6, 1'b0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk("R1 full", full, 0);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 stall idle", stall, 0);
    offer(0, 1, 0, 1, 0, 8'h00);
    #1 chk("R1 disp_ready", disp_ready, 1);
    disp_valid = 0;

    // Table walk, issue held back (R2, R9)
    for (int v = 0; v < 6; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      offer(e[23], e[22], e[21:16], e[15], e[14:9], e[8:1]);
      #1;
      chk(e[0] ? "R9 accept" : "R2/R9 refuse", disp_ready, e[0]);
      chk("R2 stall", stall, !e[0]);
      step();
    end
    disp_valid = 0;
    #1 chk("R9 full at DEPTH", full, 1);
    // R10
    chk("R10 no issue while held", iss_valid, 0);

    // R3/R6: oldest two ready entries: payload 1 then 4
    iss_ready = 1;
    #1 chk("R6 two slots", iss_valid, 2'b11);
    chk("R3 slot0 oldest", iss_payload[7:0], 8'd1);
    chk("R6 slot1 next", iss_payload[15:8], 8'd4);
    chk("R7 slot1 tid", iss_tid[1], 1'b1);
    step();
    iss_ready = 0;
    #1 chk("R9 freed", full, 0);

    // R4: non-matching wakeup leaves payload 2 waiting
    wake_valid = 2'b01; wake_tag = {6'd0, 6'd9};
    step();
    wake_valid = 0;
    iss_ready = 1;
    #1 chk("R4 nonmatch slots", iss_valid, 2'b01);
    chk("R4 nonmatch payload", iss_payload[7:0], 8'd5);
    iss_ready = 0;
    wake_valid = 2'b10; wake_tag = {6'd5, 6'd0};
    step();
    wake_valid = 0;
    iss_ready = 1;
    #1 chk("R4 woken slots", iss_valid, 2'b11);
    chk("R6 older woken first", iss_payload[7:0], 8'd2);
    chk("R6 younger second", iss_payload[15:8], 8'd5);
    step();
    #1 chk("R9 drained", iss_valid, 0);
    iss_ready = 0;

    // R5: two unready sources, same-cycle wakeup of the second one
    offer(1, 0, 6'd7, 0, 6'd8, 8'd20);
    #1 chk("R2 refused", disp_ready, 0);
    chk("R2 stall high", stall, 1);
    step();
    #1 chk("R2 still refused", disp_ready, 0);
    wake_valid = 2'b01; wake_tag = {6'd0, 6'd8};
    #1 chk("R5 accepted on wake", disp_ready, 1);
    step();
    disp_valid = 0; wake_valid = 0;
    iss_ready = 1;
    #1 chk("R5 waits other", iss_valid, 0);
    iss_ready = 0;
    wake_valid = 2'b01; wake_tag = {6'd0, 6'd7};
    step();
    wake_valid = 0;
    iss_ready = 1;
    #1 chk("R5 issued", iss_valid, 2'b01);
    chk("R7 payload", iss_payload[7:0], 8'd20);
    chk("R7 tid", iss_tid[0], 1'b1);
    step();
    iss_ready = 0;

    // R8: flush thread 0
    offer(0, 0, 6'd20, 1, 0, 8'd10); step();
    offer(1, 1, 0, 0, 6'd21, 8'd11); step();
    offer(0, 0, 6'd22, 1, 0, 8'd12); step();
    offer(0, 1, 0, 1, 0, 8'd13);
    flush = 2'b01;
    #1 chk("R8 refuse flushed tid", disp_ready, 0);
    step();
    flush = 0; disp_valid = 0;
    wake_valid = 2'b11; wake_tag = {6'd21, 6'd20};
    step();
    wake_valid = 2'b01; wake_tag = {6'd0, 6'd22};
    step();
    wake_valid = 0;
    iss_ready = 1;
    #1 chk("R8 survivor only", iss_valid, 2'b01);
    chk("R8 survivor payload", iss_payload[7:0], 8'd11);
    step();
    #1 chk("R8 none left", iss_valid, 0);
    chk("R8 not full", full, 0);
    iss_ready = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule